// File: doc/BRIEF.md
# Truth-Table Configuration Generator

This block produces the lookup-table contents for a small carry-capable functional unit. It does not run on data. It runs a short register-to-register instruction sequence over truth-table bit vectors instead. Each architectural register has a meta value: a vector indexed by the combination of two subgraph inputs and a carry-in. Logic instructions combine meta values with their own operation, so a chain of logic operations folds directly into one output table. The one addition allowed in a sequence records a generate table and a propagate table. The sum register then takes a carry-dependent meta value, which later logic instructions can consume.

Instructions arrive as a valid/ready stream, one per clock. A source register that has not been written in the current sequence is a subgraph input. Such registers receive the seed patterns in the order they are first read. A `cfg_done` pulse closes the sequence: it latches the three tables and a validity flag, and it clears all internal state so the next sequence starts fresh. Evaluate the output table bitwise, with the carry chain built from the generate and propagate tables, and it gives the same result as running the instruction sequence directly on data.

Top module: `tt_cfg_gen`

## Requirements
- R1: Table bit i stands for the input combination in which in1 = i[0], in2 = i[1] and carry = i[2]. The first distinct unwritten register read as a source receives the pattern 0xAA. The second receives 0xCC. When both sources name the same new register, it uses one seed.
- R2: Opcode 0 is AND, 1 is OR and 2 is XOR. Each applies its operation bitwise to the source meta values. The destination keeps the result, and later reads of that register return it. `out_lut` is the meta value of the destination of the last accepted instruction.
- R3: Opcode 3 is ADD. `gen_lut` is the AND of the source meta values and `prop_lut` is their XOR. The destination becomes `prop XOR 0xF0`, where 0xF0 is the carry pattern.
- R4: A logic instruction that reads an ADD destination combines its carry-dependent meta value with the other operand.
- R5: A second ADD in one sequence sets `cfg_err` and clears `cfg_valid` at the closing `cfg_done`.
- R6: A source read that would need a third distinct input sets `cfg_err` and clears `cfg_valid` at the closing `cfg_done`.
- R7: While `cfg_err` is high, all three tables read zero.
- R8: `instr_ready` is low in any cycle where `cfg_done` is high. An instruction is taken only when valid and ready are both high. The outputs change only in the cycle after a `cfg_done` and hold until the next one. Seed assignment starts over after each `cfg_done`.
- R9: Evaluate the tables on 32-bit operands a and b with carry chain c0 = 0, c(j+1) = gen[{b_j,a_j}] | (prop[{b_j,a_j}] & c_j) and result bit j = out[{c_j,b_j,a_j}]. The result equals direct execution of the sequence.
- R10: After reset, `cfg_valid` and `cfg_err` are low and all tables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Instruction can be taken this cycle |
| instr_op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 ADD |
| instr_dst | input | 4 | Destination register |
| instr_src_a | input | 4 | First source register |
| instr_src_b | input | 4 | Second source register |
| cfg_done | input | 1 | Closes the sequence and latches the tables |
| cfg_valid | output | 1 | Latched tables are usable |
| cfg_err | output | 1 | Last sequence broke a mapping limit |
| gen_lut | output | 8 | Generate table |
| prop_lut | output | 8 | Propagate table |
| out_lut | output | 8 | Output table |

## Verification
Internal state is hidden until `cfg_done`, and then a single closing cycle exposes it all. A wrong seed slot, a stale meta entry or a missed add flag shows up as a wrong table in the cycle after that pulse. A directed table comparison catches it, and so does a random-data mismatch between table evaluation and direct execution. State that survives a `cfg_done` corrupts only the next sequence, so the tests run back-to-back sequences that reuse register numbers.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2,
    OP_ADD = 2'd3
  } tt_op_e;
endpackage

// File: rtl/tt_meta_rf.sv
module tt_meta_rf #(
  parameter int NREG = 16,
  parameter int W    = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  input  logic [AW-1:0] rd_c_addr,
  output logic [W-1:0]  rd_a_data,
  output logic [W-1:0]  rd_b_data,
  output logic [W-1:0]  rd_c_data,
  output logic          rd_a_def,
  output logic          rd_b_def
);
  logic [W-1:0]    mem [NREG];
  logic [NREG-1:0] def_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q <= '0;
    end else if (clr) begin
      def_q <= '0;
    end else if (wr_en) begin
      def_q[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_addr] <= wr_data;
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
  assign rd_c_data = mem[rd_c_addr];
  assign rd_a_def  = def_q[rd_a_addr];
  assign rd_b_def  = def_q[rd_b_addr];

  p_clear_forgets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (def_q == '0));
  p_write_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> def_q[$past(wr_addr)]);
endmodule

// File: rtl/tt_seed_alloc.sv
module tt_seed_alloc #(
  parameter int NIN  = 2,
  parameter int NREG = 16,
  localparam int W   = 1 << (NIN + 1),
  localparam int AW  = $clog2(NREG),
  localparam int CW  = $clog2(NIN + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          a_def,
  input  logic          b_def,
  output logic [W-1:0]  a_seed,
  output logic [W-1:0]  b_seed,
  output logic [W-1:0]  cin_pat,
  output logic          overflow
);
  logic [W-1:0]  pat [NIN+1];
  logic [AW-1:0] slot_q [NIN];
  logic [CW-1:0] cnt_q;

  for (genvar k = 0; k <= NIN; k++) begin : g_pat
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign pat[k][i] = ((i >> k) & 1) == 1;
    end
  end
  assign cin_pat = pat[NIN];

  logic          a_hit, b_hit, a_new, b_new, b_same;
  logic [CW-1:0] a_sel, b_sel;
  logic [CW:0]   need;

  always_comb begin
    a_hit = 1'b0;
    b_hit = 1'b0;
    a_sel = cnt_q;
    b_sel = cnt_q;
    for (int k = 0; k < NIN; k++) begin
      if (CW'(k) < cnt_q && slot_q[k] == src_a) begin
        a_hit = 1'b1;
        a_sel = CW'(k);
      end
      if (CW'(k) < cnt_q && slot_q[k] == src_b) begin
        b_hit = 1'b1;
        b_sel = CW'(k);
      end
    end
    a_new  = !a_def && !a_hit;
    b_same = !b_def && !b_hit && a_new && (src_b == src_a);
    b_new  = !b_def && !b_hit && !b_same;
    if (b_new) b_sel = cnt_q + CW'(a_new);
    need     = {1'b0, cnt_q} + (CW+1)'(a_new) + (CW+1)'(b_new);
    overflow = need > (CW+1)'(NIN);
    a_seed = '0;
    b_seed = '0;
    for (int k = 0; k < NIN; k++) begin
      if (a_sel == CW'(k)) a_seed = pat[k];
      if (b_sel == CW'(k)) b_seed = pat[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < NIN; k++) slot_q[k] <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (take && !overflow) begin
      for (int k = 0; k < NIN; k++) begin
        if (a_new && cnt_q == CW'(k)) slot_q[k] <= src_a;
        if (b_new && (cnt_q + CW'(a_new)) == CW'(k)) slot_q[k] <= src_b;
      end
      cnt_q <= need[CW-1:0];
    end
  end

  p_seed_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NIN));
  p_overflow_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && overflow && !clr) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tt_meta_alu.sv
module tt_meta_alu
  import tt_pkg::*;
#(
  parameter int W = 8
) (
  input  tt_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] cin_pat,
  output logic [W-1:0] res,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  assign gen  = a & b;
  assign prop = a ^ b;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = prop ^ cin_pat;
    endcase
  end
endmodule

// File: rtl/tt_cfg_gen.sv
module tt_cfg_gen
  import tt_pkg::*;
#(
  parameter int NIN  = 2,
  parameter int NREG = 16,
  localparam int W   = 1 << (NIN + 1),
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [1:0]    instr_op,
  input  logic [AW-1:0] instr_dst,
  input  logic [AW-1:0] instr_src_a,
  input  logic [AW-1:0] instr_src_b,
  input  logic          cfg_done,
  output logic          cfg_valid,
  output logic          cfg_err,
  output logic [W-1:0]  gen_lut,
  output logic [W-1:0]  prop_lut,
  output logic [W-1:0]  out_lut
);
  tt_op_e        op;
  logic          accept, err_now, wr_en;
  logic          add_seen_q, err_q, any_wr_q;
  logic [AW-1:0] last_dst_q;
  logic [W-1:0]  gen_q, prop_q;
  logic [W-1:0]  rf_a, rf_b, rf_c, seed_a, seed_b, cin_pat;
  logic          def_a, def_b, seed_ovf;
  logic [W-1:0]  opnd_a, opnd_b, alu_res, alu_gen, alu_prop;

  assign op          = tt_op_e'(instr_op);
  assign instr_ready = !cfg_done;
  assign accept      = instr_valid && instr_ready;
  assign err_now     = seed_ovf || (op == OP_ADD && add_seen_q);
  assign wr_en       = accept && !err_q && !err_now;

  tt_meta_rf #(.NREG(NREG), .W(W)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(cfg_done),
    .wr_en(wr_en), .wr_addr(instr_dst), .wr_data(alu_res),
    .rd_a_addr(instr_src_a), .rd_b_addr(instr_src_b), .rd_c_addr(last_dst_q),
    .rd_a_data(rf_a), .rd_b_data(rf_b), .rd_c_data(rf_c),
    .rd_a_def(def_a), .rd_b_def(def_b)
  );

  tt_seed_alloc #(.NIN(NIN), .NREG(NREG)) u_seed (
    .clk(clk), .rst_n(rst_n), .clr(cfg_done),
    .take(accept && !err_q),
    .src_a(instr_src_a), .src_b(instr_src_b),
    .a_def(def_a), .b_def(def_b),
    .a_seed(seed_a), .b_seed(seed_b), .cin_pat(cin_pat),
    .overflow(seed_ovf)
  );

  assign opnd_a = def_a ? rf_a : seed_a;
  assign opnd_b = def_b ? rf_b : seed_b;

  tt_meta_alu #(.W(W)) u_alu (
    .op(op), .a(opnd_a), .b(opnd_b), .cin_pat(cin_pat),
    .res(alu_res), .gen(alu_gen), .prop(alu_prop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_seen_q <= 1'b0;
      err_q      <= 1'b0;
      any_wr_q   <= 1'b0;
      last_dst_q <= '0;
      gen_q      <= '0;
      prop_q     <= '0;
    end else if (cfg_done) begin
      add_seen_q <= 1'b0;
      err_q      <= 1'b0;
      any_wr_q   <= 1'b0;
      gen_q      <= '0;
      prop_q     <= '0;
    end else if (accept) begin
      if (err_now) err_q <= 1'b1;
      if (wr_en) begin
        any_wr_q   <= 1'b1;
        last_dst_q <= instr_dst;
        if (op == OP_ADD) begin
          add_seen_q <= 1'b1;
          gen_q      <= alu_gen;
          prop_q     <= alu_prop;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
      gen_lut   <= '0;
      prop_lut  <= '0;
      out_lut   <= '0;
    end else if (cfg_done) begin
      cfg_valid <= !err_q;
      cfg_err   <= err_q;
      gen_lut   <= err_q ? '0 : gen_q;
      prop_lut  <= err_q ? '0 : prop_q;
      out_lut   <= (err_q || !any_wr_q) ? '0 : rf_c;
    end
  end

  p_err_tables_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (gen_lut == '0 && prop_lut == '0 && out_lut == '0));
  p_valid_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_err));
  p_add_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_seen_q && !cfg_done) |=> add_seen_q);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> ($stable(out_lut) && $stable(cfg_valid) && $stable(gen_lut)));
  p_no_take_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && instr_valid) |=> !$past(wr_en));
endmodule

// File: tb/tt_cfg_gen_tb.sv
module tt_cfg_gen_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       instr_valid = 0;
  logic       instr_ready;
  logic [1:0] instr_op = 0;
  logic [3:0] instr_dst = 0, instr_src_a = 0, instr_src_b = 0;
  logic       cfg_done = 0;
  logic       cfg_valid, cfg_err;
  logic [7:0] gen_lut, prop_lut, out_lut;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tt_cfg_gen u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_dst(instr_dst), .instr_src_a(instr_src_a),
    .instr_src_b(instr_src_b), .cfg_done(cfg_done), .cfg_valid(cfg_valid),
    .cfg_err(cfg_err), .gen_lut(gen_lut), .prop_lut(prop_lut), .out_lut(out_lut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [3:0] d, logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    instr_valid = 1; instr_op = op; instr_dst = d; instr_src_a = a; instr_src_b = b;
    @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic close_cfg();
    cfg_done = 1;
    @(negedge clk);
    cfg_done = 0;
  endtask

  task automatic expect_tables(string req, logic v, logic e, logic [7:0] g, logic [7:0] p, logic [7:0] o);
    chk({req, " valid"}, cfg_valid, v);
    chk({req, " err"}, cfg_err, e);
    chk({req, " gen"}, gen_lut, g);
    chk({req, " prop"}, prop_lut, p);
    chk({req, " out"}, out_lut, o);
  endtask

  function automatic logic [31:0] eval_tbl(logic [7:0] g, logic [7:0] p, logic [7:0] o,
                                           logic [31:0] a, logic [31:0] b);
    logic c = 0;
    logic [31:0] r;
    for (int j = 0; j < 32; j++) begin
      r[j] = o[{c, b[j], a[j]}];
      c = g[{1'b0, b[j], a[j]}] | (p[{1'b0, b[j], a[j]}] & c);
    end
    return r;
  endfunction

  task automatic random_cmp(string req, int prog);
    for (int n = 0; n < 20; n++) begin
      logic [31:0] a = $urandom, b = $urandom, exp;
      case (prog)
        0: exp = (a & b) ^ (a + b);
        1: exp = (a + b) | a;
        default: exp = (a ^ b) | (a & b);
      endcase
      chk(req, eval_tbl(gen_lut, prop_lut, out_lut, a, b), exp);
    end
  endtask

  task automatic t_reset();
    expect_tables("R10", 0, 0, 8'h00, 8'h00, 8'h00);
    chk("R8 ready", instr_ready, 1);
  endtask

  task automatic t_single_and();
    send(0, 3, 1, 2);
    close_cfg();
    expect_tables("R1", 1, 0, 8'h00, 8'h00, 8'h88);
  endtask

  task automatic t_logic_chain();
    send(2, 6, 1, 2);
    send(0, 7, 1, 2);
    send(1, 12, 6, 7);
    close_cfg();
    expect_tables("R2", 1, 0, 8'h00, 8'h00, 8'hEE);
    random_cmp("R9 logic", 2);
  endtask

  task automatic t_same_src_and_overwrite();
    send(1, 2, 5, 5);
    send(0, 3, 2, 6);
    close_cfg();
    expect_tables("R1 same-src", 1, 0, 8'h00, 8'h00, 8'h88);
    send(0, 1, 1, 2);
    send(1, 1, 1, 2);
    close_cfg();
    expect_tables("R2 overwrite", 1, 0, 8'h00, 8'h00, 8'hCC);
  endtask

  task automatic t_add_chain();
    send(0, 3, 1, 2);
    send(3, 4, 1, 2);
    send(2, 5, 3, 4);
    close_cfg();
    expect_tables("R4", 1, 0, 8'h88, 8'h66, 8'h1E);
    random_cmp("R9 add-xor", 0);
  endtask

  task automatic t_add_alone();
    send(3, 3, 1, 2);
    close_cfg();
    expect_tables("R3", 1, 0, 8'h88, 8'h66, 8'h96);
    send(3, 3, 1, 2);
    send(1, 4, 3, 1);
    close_cfg();
    expect_tables("R4 or", 1, 0, 8'h88, 8'h66, 8'hBE);
    random_cmp("R9 add-or", 1);
  endtask

  task automatic t_two_adds();
    send(3, 3, 1, 2);
    send(3, 4, 3, 1);
    close_cfg();
    expect_tables("R5", 0, 1, 8'h00, 8'h00, 8'h00);
    chk("R7 zero", {gen_lut, prop_lut, out_lut}, 0);
  endtask

  task automatic t_third_input();
    send(0, 3, 1, 2);
    send(1, 4, 3, 5);
    close_cfg();
    expect_tables("R6", 0, 1, 8'h00, 8'h00, 8'h00);
    chk("R7 zero", out_lut, 0);
  endtask

  task automatic t_done_handshake();
    send(2, 3, 1, 2);
    @(negedge clk);
    instr_valid = 1; instr_op = 1; instr_dst = 4; instr_src_a = 3; instr_src_b = 3;
    cfg_done = 1;
    #1 chk("R8 ready low", instr_ready, 0);
    @(negedge clk);
    instr_valid = 0; cfg_done = 0;
    expect_tables("R8 not taken", 1, 0, 8'h00, 8'h00, 8'h66);
    send(1, 4, 3, 9);
    chk("R8 hold", out_lut, 8'h66);
    chk("R8 hold valid", cfg_valid, 1);
    close_cfg();
    expect_tables("R8 restart", 1, 0, 8'h00, 8'h00, 8'hEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_and();
    t_logic_chain();
    t_same_src_and_overwrite();
    t_add_alone();
    t_add_chain();
    t_two_adds();
    t_third_input();
    t_done_handshake();
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule